// File: doc/BRIEF.md
# Reloadable Up-Counting Interval Timer

This block is a free-running upward counter with a small register port. Software starts and stops it with a control bit, can overwrite the count at any moment, and can force a reload from a separate reload register by writing anything to a dedicated trigger address. The counter advances by one on each cycle in which the count-enable input is high while the timer runs.

When the count steps past all-ones, an overflow event occurs. In reload mode the counter takes the reload value and keeps running. In one-shot mode it parks at zero and hardware clears the run bit, so a read of the control register shows that the timer has stopped. Each overflow sets a sticky status flag that drives the interrupt output through an enable bit. A single output pin can mark each overflow with one positive pulse that lasts one count-enable period, or it can flip its level on each overflow. The pin can also be held low.

Register map (word addresses on `addr`): 0 control (bit0 run, bit1 reload mode, bit2 pin enable, bit3 pin toggle select). 1 count. 2 reload value. 3 trigger (write only, reads 0). 4 interrupt enable (bit0). 5 status (bit0 overflow flag, write 1 to clear). Other addresses read 0 and ignore writes. Writes take effect at the clock edge. `rdata` is a combinational view of the addressed register.

Top module: `interval_timer`

## Requirements
- R1: After reset the count is 0, the run bit is 0, the status flag is 0, and `irq` and `tmr_out` are low. The timer stays stopped after reset is released.
- R2: While the run bit (control bit0) is 1, the count goes up by one on each clock edge where `tick_en` is high. With run at 0 or `tick_en` low, the count holds its value, and counting resumes from that value.
- R3: A write to address 1 loads `wdata` into the count at that edge, whether the timer is running or stopped. If an overflow happens in the same cycle, the written value takes precedence over the overflow reload.
- R4: A write of any data to address 3 copies the reload register (address 2) into the count.
- R5: An overflow is a counting step taken when the count is all-ones. If control bit1 is 1, the count becomes the reload value and the run bit stays 1.
- R6: If control bit1 is 0, an overflow leaves the count at 0 and clears the run bit, so control bit0 reads 0.
- R7: Each overflow sets status bit0. The bit stays set until a write to address 5 with bit0 equal to 1. Writing 0 to that bit has no effect, and a new overflow in the clearing cycle wins.
- R8: `irq` is high exactly when status bit0 and interrupt-enable bit0 (address 4) are both 1.
- R9: With control bit2 = 1 and bit3 = 0, `tmr_out` goes high at the edge of an overflow. It returns low at the next edge where `tick_en` is high, so the pulse lasts one count-enable period.
- R10: With control bit2 = 1 and bit3 = 1, `tmr_out` flips its level at each overflow edge and otherwise holds it.
- R11: With control bit2 = 0, `tmr_out` is low one edge later and stays low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tick_en | input | 1 | Count enable (one prescaler period per high cycle) |
| wr_en | input | 1 | Register write strobe |
| addr | input | ADDR_W | Register word address |
| wdata | input | CNT_W | Write data |
| rdata | output | CNT_W | Read data of the addressed register |
| irq | output | 1 | Overflow interrupt |
| tmr_out | output | 1 | Overflow pulse/toggle pin |

## Verification
The bench builds the block with its defaults: a 32-bit counter and a 3-bit address. A natural overflow would therefore need about four billion ticks. To reach it in a few cycles, the bench writes the count to values just below all-ones, including in its random phase, which biases count writes toward the top of the range. With this, overflow in both modes can be exercised repeatedly. So can the collision of a count write with an overflow, the pulse held across idle `tick_en` cycles, and toggling across successive overflows.

// File: rtl/interval_timer.sv
module interval_timer #(
  parameter int CNT_W  = 32,
  parameter int ADDR_W = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tick_en,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] addr,
  input  logic [CNT_W-1:0]  wdata,
  output logic [CNT_W-1:0]  rdata,
  output logic              irq,
  output logic              tmr_out
);
  localparam logic [ADDR_W-1:0] A_CTRL = ADDR_W'(0);
  localparam logic [ADDR_W-1:0] A_CNT  = ADDR_W'(1);
  localparam logic [ADDR_W-1:0] A_LD   = ADDR_W'(2);
  localparam logic [ADDR_W-1:0] A_TRG  = ADDR_W'(3);
  localparam logic [ADDR_W-1:0] A_IE   = ADDR_W'(4);
  localparam logic [ADDR_W-1:0] A_STAT = ADDR_W'(5);

  logic [CNT_W-1:0] count_q, load_q;
  logic run_q, ar_q, oen_q, tgl_q, ie_q, flag_q, out_q;

  logic step, ovf;
  logic wr_ctrl, wr_cnt, wr_ld, wr_trg, wr_ie, wr_stat;

  assign wr_ctrl = wr_en && addr == A_CTRL;
  assign wr_cnt  = wr_en && addr == A_CNT;
  assign wr_ld   = wr_en && addr == A_LD;
  assign wr_trg  = wr_en && addr == A_TRG;
  assign wr_ie   = wr_en && addr == A_IE;
  assign wr_stat = wr_en && addr == A_STAT;

  assign step = run_q && tick_en;
  assign ovf  = step && (count_q == '1);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      count_q <= '0;
    end else if (wr_cnt) begin
      count_q <= wdata;
    end else if (wr_trg) begin
      count_q <= load_q;
    end else if (ovf) begin
      count_q <= ar_q ? load_q : '0;
    end else if (step) begin
      count_q <= count_q + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      run_q <= 1'b0;
      ar_q  <= 1'b0;
      oen_q <= 1'b0;
      tgl_q <= 1'b0;
    end else if (wr_ctrl) begin
      run_q <= wdata[0];
      ar_q  <= wdata[1];
      oen_q <= wdata[2];
      tgl_q <= wdata[3];
    end else if (ovf && !ar_q) begin
      run_q <= 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      load_q <= '0;
      ie_q   <= 1'b0;
    end else begin
      if (wr_ld) load_q <= wdata;
      if (wr_ie) ie_q <= wdata[0];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                flag_q <= 1'b0;
    else if (ovf)              flag_q <= 1'b1;
    else if (wr_stat && wdata[0]) flag_q <= 1'b0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       out_q <= 1'b0;
    else if (!oen_q)  out_q <= 1'b0;
    else if (tgl_q)   out_q <= ovf ? ~out_q : out_q;
    else if (ovf)     out_q <= 1'b1;
    else if (tick_en) out_q <= 1'b0;
  end

  assign irq     = flag_q && ie_q;
  assign tmr_out = out_q;

  always_comb begin
    case (addr)
      A_CTRL:  rdata = {{(CNT_W-4){1'b0}}, tgl_q, oen_q, ar_q, run_q};
      A_CNT:   rdata = count_q;
      A_LD:    rdata = load_q;
      A_IE:    rdata = {{(CNT_W-1){1'b0}}, ie_q};
      A_STAT:  rdata = {{(CNT_W-1){1'b0}}, flag_q};
      default: rdata = '0;
    endcase
  end
endmodule

// File: rtl/interval_timer_chk.sv
module interval_timer_chk #(
  parameter int CNT_W  = 32,
  parameter int ADDR_W = 3
) (
  input logic              clk,
  input logic              rst_n,
  input logic              tick_en,
  input logic              wr_en,
  input logic [ADDR_W-1:0] addr,
  input logic [CNT_W-1:0]  wdata,
  input logic [CNT_W-1:0]  count_q,
  input logic              run_q,
  input logic              ar_q,
  input logic              oen_q,
  input logic              tgl_q,
  input logic              ie_q,
  input logic              irq,
  input logic              tmr_out
);
  localparam logic [ADDR_W-1:0] C_CNT = ADDR_W'(1);
  localparam logic [ADDR_W-1:0] C_TRG = ADDR_W'(3);
  localparam logic [ADDR_W-1:0] C_IE  = ADDR_W'(4);

  logic at_top, cnt_wr, any_load;
  assign at_top   = run_q && tick_en && (count_q == '1);
  assign cnt_wr   = wr_en && addr == C_CNT;
  assign any_load = wr_en && (addr == C_CNT || addr == C_TRG);

  p_reset_state_r1: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rst_n) |-> (count_q == '0 && !run_q && !irq && !tmr_out));

  p_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (!(run_q && tick_en) && !any_load) |=> $stable(count_q));

  p_step_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (run_q && tick_en && count_q != '1 && !wr_en) |=> count_q == $past(count_q) + 1'b1);

  p_write_r3: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_wr |=> count_q == $past(wdata));

  p_oneshot_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (at_top && !ar_q && !wr_en) |=> (count_q == '0 && !run_q));

  p_irq_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (at_top && ie_q && !(wr_en && addr == C_IE)) |=> irq);

  p_toggle_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (at_top && oen_q && tgl_q) |=> tmr_out != $past(tmr_out));

  p_pin_off_r11: assert property (@(posedge clk) disable iff (!rst_n)
    !oen_q |=> !tmr_out);
endmodule

bind interval_timer interval_timer_chk #(.CNT_W(CNT_W), .ADDR_W(ADDR_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .tick_en(tick_en), .wr_en(wr_en), .addr(addr),
  .wdata(wdata), .count_q(count_q), .run_q(run_q), .ar_q(ar_q), .oen_q(oen_q),
  .tgl_q(tgl_q), .ie_q(ie_q), .irq(irq), .tmr_out(tmr_out)
);

// File: tb/interval_timer_tb.sv
`timescale 1ns/100ps
module interval_timer_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        tick_en = 1'b0;
  logic        wr_en = 1'b0;
  logic [2:0]  addr = 3'd0;
  logic [31:0] wdata = 32'd0;
  logic [31:0] rdata;
  logic        irq, tmr_out;

  int n_chk = 0;
  int n_fail = 0;

  always #2 clk = ~clk;

  interval_timer u_dut (
    .clk(clk), .rst_n(rst_n), .tick_en(tick_en), .wr_en(wr_en), .addr(addr),
    .wdata(wdata), .rdata(rdata), .irq(irq), .tmr_out(tmr_out)
  );

  logic [31:0] m_cnt, m_ld;
  logic m_run, m_ar, m_oen, m_tgl, m_ie, m_flag, m_out;

  function automatic logic [31:0] ctrl_word();
    return {28'd0, m_tgl, m_oen, m_ar, m_run};
  endfunction

  task automatic model_reset();
    m_cnt = 0; m_ld = 0; m_run = 0; m_ar = 0; m_oen = 0; m_tgl = 0;
    m_ie = 0; m_flag = 0; m_out = 0;
  endtask

  task automatic model_step(input logic we, input logic [2:0] a, input logic [31:0] d, input logic te);
    logic st, ov;
    logic [31:0] n_cnt;
    logic n_run, n_flag, n_out;
    st = m_run && te;
    ov = st && (m_cnt == 32'hFFFF_FFFF);
    if (we && a == 3'd1)      n_cnt = d;
    else if (we && a == 3'd3) n_cnt = m_ld;
    else if (ov)              n_cnt = m_ar ? m_ld : 32'd0;
    else if (st)              n_cnt = m_cnt + 1;
    else                      n_cnt = m_cnt;
    if (we && a == 3'd0)      n_run = d[0];
    else if (ov && !m_ar)     n_run = 1'b0;
    else                      n_run = m_run;
    if (ov)                            n_flag = 1'b1;
    else if (we && a == 3'd5 && d[0])  n_flag = 1'b0;
    else                               n_flag = m_flag;
    if (!m_oen)      n_out = 1'b0;
    else if (m_tgl)  n_out = ov ? !m_out : m_out;
    else if (ov)     n_out = 1'b1;
    else if (te)     n_out = 1'b0;
    else             n_out = m_out;
    if (we && a == 3'd0) begin m_ar = d[1]; m_oen = d[2]; m_tgl = d[3]; end
    if (we && a == 3'd2) m_ld = d;
    if (we && a == 3'd4) m_ie = d[0];
    m_cnt = n_cnt; m_run = n_run; m_flag = n_flag; m_out = n_out;
  endtask

  task automatic check(input string tag, input string what, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s: actual %h expected %h", tag, what, act, exp);
    end
  endtask

  task automatic compare(input string tag);
    addr = 3'd1; #0.3;
    check(tag, "count", rdata, m_cnt);
    addr = 3'd0; #0.3;
    check(tag, "control", rdata, ctrl_word());
    addr = 3'd5; #0.3;
    check({tag, "/R7"}, "status", rdata, {31'd0, m_flag});
    check({tag, "/R8"}, "irq", {31'd0, irq}, {31'd0, m_flag && m_ie});
    check({tag, "/R9/R10/R11"}, "tmr_out", {31'd0, tmr_out}, {31'd0, m_out});
  endtask

  task automatic cyc(input logic we, input logic [2:0] a, input logic [31:0] d, input logic te, input string tag);
    wr_en = we; addr = a; wdata = d; tick_en = te;
    @(posedge clk);
    model_step(we, a, d, te);
    @(negedge clk);
    wr_en = 1'b0; tick_en = 1'b0;
    compare(tag);
  endtask

  task automatic wr(input logic [2:0] a, input logic [31:0] d, input string tag);
    cyc(1'b1, a, d, 1'b0, tag);
  endtask

  task automatic idle(input int n, input logic te, input string tag);
    for (int i = 0; i < n; i++) cyc(1'b0, 3'd0, 32'd0, te, tag);
  endtask

  initial begin
    #(4 * 200000);
    n_chk++; n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
    $finish;
  end

  initial begin
    int unsigned seed_v;
    logic [31:0] rv;
    model_reset();
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    compare("R1");
    idle(2, 1'b1, "R1");

    wr(3'd0, 32'd1, "R2");
    idle(3, 1'b1, "R2");
    idle(2, 1'b0, "R2");
    wr(3'd0, 32'd0, "R2");
    idle(2, 1'b1, "R2");
    wr(3'd0, 32'd1, "R2");
    idle(1, 1'b1, "R2");

    wr(3'd1, 32'h0000_1234, "R3");
    cyc(1'b1, 3'd1, 32'h0000_0100, 1'b1, "R3");

    wr(3'd2, 32'h0000_0010, "R4");
    cyc(1'b1, 3'd3, 32'hDEAD_BEEF, 1'b1, "R4");

    wr(3'd4, 32'd1, "R8");
    wr(3'd0, 32'd7, "R5");
    wr(3'd1, 32'hFFFF_FFFE, "R5");
    idle(3, 1'b1, "R5");
    cyc(1'b1, 3'd5, 32'd0, 1'b0, "R7");
    idle(2, 1'b0, "R9");
    idle(1, 1'b1, "R9");
    cyc(1'b1, 3'd5, 32'd1, 1'b0, "R7");

    wr(3'd0, 32'hF, "R10");
    wr(3'd1, 32'hFFFF_FFFF, "R10");
    idle(1, 1'b1, "R10");
    wr(3'd1, 32'hFFFF_FFFF, "R10");
    idle(2, 1'b1, "R10");

    wr(3'd0, 32'd5, "R6");
    wr(3'd1, 32'hFFFF_FFFE, "R6");
    idle(4, 1'b1, "R6");

    wr(3'd0, 32'd3, "R3");
    wr(3'd1, 32'hFFFF_FFFF, "R3");
    cyc(1'b1, 3'd1, 32'd5, 1'b1, "R3");

    wr(3'd1, 32'hFFFF_FFFF, "R7");
    cyc(1'b1, 3'd5, 32'd1, 1'b1, "R7");

    wr(3'd0, 32'd3, "R11");
    wr(3'd1, 32'hFFFF_FFFF, "R11");
    idle(2, 1'b1, "R11");
    wr(3'd4, 32'd0, "R8");

    seed_v = 32'd12345;
    rv = $urandom(seed_v);
    for (int i = 0; i < 4000; i++) begin
      logic we, te;
      logic [2:0] a;
      logic [31:0] d;
      rv = $urandom();
      we = (rv[4:0] < 5'd6);
      te = (rv[7:6] != 2'd0);
      a  = rv[10:8];
      d  = $urandom();
      if (we && a == 3'd1 && rv[12]) d = 32'hFFFF_FFF0 | {28'd0, d[3:0]};
      if (we && a == 3'd0 && rv[13]) d[0] = 1'b1;
      cyc(we, a, d, te, "R2/R5/R6");
    end

    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
    $finish;
  end
endmodule